// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a serial control link that reads and writes a small bank of 8-bit configuration registers. The host selects the port by pulling an active-low select line, toggles a serial clock, and sends one instruction byte followed by one to four data bytes on a bidirectional data line. The register contents are presented in parallel to the rest of the chip on `cfg_o`.

The serial pins are not used as clocks. All state runs on the system clock `clk`; the select, serial clock and data inputs are registered once and serial clock edges are found by comparing successive samples. Each half period of the serial clock must last at least three `clk` cycles. The data line is split into an input, an output value and an output enable, and the separate data output has its own value and enable, so the pad ring builds the tri-state buffers.

Read data comes back either on the bidirectional line (three-wire operation) or on the separate output (four-wire operation). The choice is bit 0 of register 0, taken at the moment the instruction byte completes.

Top module: `ctl_serial_port`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, every register clears to 0x00, and both output enables go low.
- R2: The instruction byte is shifted MSB first, one bit on each rising serial clock edge. Bit 7 = 1 means read and 0 means write. Bits 6:5 hold a length code L, and the transfer carries L+1 data bytes. Bits 4:0 hold the start address; its low log2(REG_COUNT) bits pick the register.
- R3: No output enable is asserted before the instruction byte is complete.
- R4: Write data bytes are shifted MSB first. Each byte lands in its register once its eighth bit has been sampled. The address steps by one per byte and wraps modulo REG_COUNT. Bits sent after the L+1 bytes change nothing.
- R5: When select rises partway through a data byte, the register that byte was aimed at keeps its old value.
- R6: On a read with register 0 bit 0 = 0, the bidirectional line is driven. D7 of the first byte appears after the first falling serial clock edge that follows the instruction. Each later falling edge presents the next bit, MSB first, with the address stepping per byte. Outputs settle within three `clk` cycles of the falling edge, and `dout_oe` stays low.
- R7: On a read with register 0 bit 0 = 1, the same bit sequence is driven on `dout`, and `dio_oe` stays low.
- R8: On a read, the falling edge that follows the last data bit drives the active output low, and it stays low while select is held. Once select rises, both enables drop within three `clk` cycles.
- R9: While select is high, the bit count and phase return to idle. An instruction abandoned partway leaves the registers untouched, and the next selection starts with a fresh instruction.
- R10: `cfg_o` bits 8*i+7 to 8*i carry register i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low port select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| dio_in | input | 1 | Bidirectional data line, input side |
| dio_out | output | 1 | Bidirectional data line, output value |
| dio_oe | output | 1 | Output enable for the bidirectional line |
| dout | output | 1 | Separate serial data output value |
| dout_oe | output | 1 | Output enable for the separate output |
| cfg_o | output | 8*REG_COUNT | Parallel view of all registers |

## Verification
The assertions check several properties on every cycle. No output is enabled during the instruction phase, and the two enables are never high together. Deselection returns the sequencer to idle with its outputs released. The tail after a read drives low. Registers change only on a write strobe, and each strobe lands its byte. Other behaviour needs the bench's scenarios: MSB-first ordering, address wrap across a four-byte burst, ignored surplus bits, the truncated-write and abandoned-instruction cases, and the switch to four-wire operation after register 0 is rewritten. The bench checks these against a behavioural model at every serial clock half period.

// File: rtl/csp_pkg.sv
// Package: shared constants and types for the serial configuration port.
// Assumes 8-bit instruction and data bytes; register 0 bit 0 selects four-wire readback.
package csp_pkg;
    localparam int BYTE_W   = 8;
    localparam int LEN_W    = 2;
    localparam int MODE_REG = 0;
    localparam int MODE_BIT = 0;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_TAIL  = 2'd2
    } phase_t;
endpackage

// File: rtl/csp_pin_sampler.sv
// Module: registers the serial pins into the clk domain and flags serial clock edges.
// Assumes each serial clock half period spans at least three clk cycles.
module csp_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic ser_clk,
    input  logic dio_in,
    output logic sel_o,
    output logic rise_o,
    output logic fall_o,
    output logic din_o
);
    logic sel_q, sck_q, sck_d, din_q;

    // Capture pins and keep one older serial clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b1;
            sck_q <= 1'b0;
            sck_d <= 1'b0;
            din_q <= 1'b0;
        end else begin
            sel_q <= sel_n;
            sck_q <= ser_clk;
            sck_d <= sck_q;
            din_q <= dio_in;
        end
    end

    assign sel_o  = ~sel_q;
    assign rise_o = sck_q & ~sck_d & ~sel_q;
    assign fall_o = ~sck_q & sck_d & ~sel_q;
    assign din_o  = din_q;
endmodule

// File: rtl/csp_reg_bank.sv
// Module: the 8-bit configuration registers with one write port and one read port.
// Assumes REG_COUNT is a power of two; register MODE_REG bit MODE_BIT is the readback mode.
module csp_reg_bank #(
    parameter int REG_COUNT = 16,
    localparam int IDX_W = $clog2(REG_COUNT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [csp_pkg::BYTE_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [csp_pkg::BYTE_W-1:0]     rd_data,
    output logic                           mode4_o,
    output logic [REG_COUNT*csp_pkg::BYTE_W-1:0] cfg_o
);
    logic [REG_COUNT-1:0][csp_pkg::BYTE_W-1:0] regs;

    // Clear on reset, otherwise store a completed write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];
    assign mode4_o = regs[csp_pkg::MODE_REG][csp_pkg::MODE_BIT];
    assign cfg_o   = regs;

    // R5: registers only move on a write strobe.
    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R4: a strobed byte is present in its register on the next cycle.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/csp_sequencer.sv
// Module: instruction decode, byte and bit counting, write strobes and read shifting.
// Assumes edge flags from csp_pin_sampler; rise and fall never occur in the same cycle.
module csp_sequencer #(
    parameter int IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_i,
    input  logic                       rise_i,
    input  logic                       fall_i,
    input  logic                       din_i,
    input  logic                       mode4_i,
    input  logic [csp_pkg::BYTE_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]           idx_o,
    output logic                       wr_en_o,
    output logic [csp_pkg::BYTE_W-1:0] wr_data_o,
    output logic                       drive_o,
    output logic                       four_o,
    output logic                       bit_o
);
    import csp_pkg::*;

    phase_t                  phase;
    logic [2:0]              bit_cnt;
    logic [BYTE_W-2:0]       shreg;
    logic [BYTE_W-1:0]       tx;
    logic [LEN_W-1:0]        left;
    logic [IDX_W-1:0]        idx;
    logic                    is_rd, four_q, drive_q, bit_q;

    logic [BYTE_W-1:0] byte_in;
    logic              byte_done;

    // Form the byte completed by the current sample and flag its eighth bit.
    always_comb begin
        byte_in   = {shreg, din_i};
        byte_done = rise_i && (bit_cnt == 3'd7);
    end

    // Phase, counters, read shifter and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            left    <= '0;
            idx     <= '0;
            is_rd   <= 1'b0;
            four_q  <= 1'b0;
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else if (!sel_i) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            if (rise_i && phase != PH_TAIL) begin
                shreg   <= byte_in[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done && phase == PH_INSTR) begin
                is_rd  <= byte_in[7];
                left   <= byte_in[6:5];
                idx    <= byte_in[IDX_W-1:0];
                four_q <= mode4_i;
                phase  <= PH_DATA;
            end else if (byte_done && phase == PH_DATA) begin
                if (left == '0) begin
                    phase <= PH_TAIL;
                end else begin
                    left <= left - 1'b1;
                    idx  <= idx + 1'b1;
                end
            end
            if (fall_i && is_rd && phase == PH_DATA) begin
                drive_q <= 1'b1;
                if (bit_cnt == 3'd0) begin
                    bit_q <= rd_data_i[BYTE_W-1];
                    tx    <= {rd_data_i[BYTE_W-2:0], 1'b0};
                end else begin
                    bit_q <= tx[BYTE_W-1];
                    tx    <= {tx[BYTE_W-2:0], 1'b0};
                end
            end else if (fall_i && is_rd && phase == PH_TAIL) begin
                drive_q <= 1'b1;
                bit_q   <= 1'b0;
            end
        end
    end

    assign idx_o     = idx;
    assign wr_en_o   = sel_i && byte_done && phase == PH_DATA && !is_rd;
    assign wr_data_o = byte_in;
    assign drive_o   = drive_q;
    assign four_o    = four_q;
    assign bit_o     = bit_q;

    // R3: nothing is driven while the instruction is still arriving.
    a_r3_instr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INSTR) |-> !drive_q);

    // R9: deselection returns the sequencer to idle with outputs released.
    a_r9_idle_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (!drive_q && phase == PH_INSTR && bit_cnt == 3'd0));

    // R8: a falling edge after the last read bit drives a low level.
    a_r8_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && fall_i && is_rd && phase == PH_TAIL) |=> (drive_q && !bit_q));
endmodule

// File: rtl/ctl_serial_port.sv
// Module: top of the serial configuration port; joins sampler, sequencer and register bank
// and splits the read drive between the bidirectional line and the separate output.
// Assumes the pad ring builds the tri-state buffers from the value/enable pairs.
module ctl_serial_port #(
    parameter int REG_COUNT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_n,
    input  logic                       ser_clk,
    input  logic                       dio_in,
    output logic                       dio_out,
    output logic                       dio_oe,
    output logic                       dout,
    output logic                       dout_oe,
    output logic [REG_COUNT*8-1:0]     cfg_o
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic sel, rise, fall, din, mode4, wr_en, drive, four, obit;
    logic [IDX_W-1:0] idx;
    logic [7:0] rd_data, wr_data;

    csp_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .dio_in(dio_in),
        .sel_o(sel), .rise_o(rise), .fall_o(fall), .din_o(din)
    );

    csp_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .rise_i(rise), .fall_i(fall), .din_i(din),
        .mode4_i(mode4), .rd_data_i(rd_data), .idx_o(idx), .wr_en_o(wr_en),
        .wr_data_o(wr_data), .drive_o(drive), .four_o(four), .bit_o(obit)
    );

    csp_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data),
        .rd_idx(idx), .rd_data(rd_data), .mode4_o(mode4), .cfg_o(cfg_o)
    );

    // Route the read bit to whichever pin the latched mode selects.
    always_comb begin
        dio_out = obit;
        dout    = obit;
        dio_oe  = drive & ~four;
        dout_oe = drive & four;
    end

    // R7: the two output enables are never active together.
    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(dio_oe && dout_oe));
endmodule

// File: tb/ctl_serial_port_tb.sv
// Bench: drives serial transactions and compares pins against a behavioural model
// at the end of every serial clock half period.
module ctl_serial_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic ser_clk = 1'b0;
    logic dio_in = 1'b0;
    logic dio_out, dio_oe, dout, dout_oe;
    logic [NREG*8-1:0] cfg_o;

    logic [NREG-1:0][7:0] mreg;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_serial_port #(.REG_COUNT(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .dio_in(dio_in),
        .dio_out(dio_out), .dio_oe(dio_oe), .dout(dout), .dout_oe(dout_oe), .cfg_o(cfg_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    // Compare pins for transaction bit position p against the model.
    task automatic check_pins(input bit rd, input int p, input bit m4, input int nb,
                              input logic [7:0] rb [4]);
        int j;
        logic expv;
        if (rd && p >= 8) begin
            j = p - 8;
            expv = (j < 8*nb) ? rb[j/8][7 - (j%8)] : 1'b0;
            if (m4) begin
                chk("R7", "dout_oe", {127'd0, dout_oe}, 128'd1);
                chk("R7", "dio_oe", {127'd0, dio_oe}, 128'd0);
                chk((j < 8*nb) ? "R7" : "R8", "dout", {127'd0, dout}, {127'd0, expv});
            end else begin
                chk("R6", "dio_oe", {127'd0, dio_oe}, 128'd1);
                chk("R6", "dout_oe", {127'd0, dout_oe}, 128'd0);
                chk((j < 8*nb) ? "R2/R6" : "R8", "dio_out", {127'd0, dio_out}, {127'd0, expv});
            end
        end else begin
            chk("R3", "dio_oe", {127'd0, dio_oe}, 128'd0);
            chk("R3", "dout_oe", {127'd0, dout_oe}, 128'd0);
        end
    endtask

    // One full transaction of 8 instruction bits plus dbits data bits.
    task automatic txn(input logic [7:0] ins, input int dbits,
                       input logic [7:0] w0, input logic [7:0] w1,
                       input logic [7:0] w2, input logic [7:0] w3);
        logic [7:0] wb [4];
        logic [7:0] rb [4];
        bit rd;
        bit m4;
        int nb;
        int a;
        int j;
        wb[0] = w0; wb[1] = w1; wb[2] = w2; wb[3] = w3;
        rd = ins[7];
        nb = int'(ins[6:5]) + 1;
        a  = int'(ins[3:0]);
        m4 = 1'b0;
        for (int k = 0; k < 4; k++) rb[k] = 8'h00;
        sel_n = 1'b0;
        wait_half();
        for (int p = 0; p < 8 + dbits; p++) begin
            ser_clk = 1'b0;
            j = p - 8;
            if (p < 8) dio_in = ins[7 - p];
            else if (!rd && j < 32) dio_in = wb[j/8][7 - (j%8)];
            else dio_in = 1'b0;
            if (p == 8) begin
                m4 = mreg[0][0];
                for (int k = 0; k < 4; k++) rb[k] = mreg[(a + k) % NREG];
            end
            wait_half();
            check_pins(rd, p, m4, nb, rb);
            ser_clk = 1'b1;
            if (!rd && p >= 8 && (j % 8) == 7 && (j / 8) < nb)
                mreg[(a + j/8) % NREG] = wb[j/8];
            wait_half();
            check_pins(rd, p, m4, nb, rb);
            chk(rd ? "R10" : "R4", "cfg", cfg_o, mreg);
        end
        ser_clk = 1'b0;
        dio_in = 1'b0;
        wait_half();
        check_pins(rd, 8 + dbits, m4, nb, rb);
        sel_n = 1'b1;
        wait_half();
        chk("R8", "dio_oe after deselect", {127'd0, dio_oe}, 128'd0);
        chk("R8", "dout_oe after deselect", {127'd0, dout_oe}, 128'd0);
        chk("R10", "cfg after deselect", cfg_o, mreg);
    endtask

    // Abandon an instruction after a few bits.
    task automatic abort_instr(input logic [7:0] ins, input int nbits);
        sel_n = 1'b0;
        wait_half();
        for (int p = 0; p < nbits; p++) begin
            ser_clk = 1'b0;
            dio_in = ins[7 - p];
            wait_half();
            ser_clk = 1'b1;
            wait_half();
            chk("R3", "dio_oe in partial instr", {127'd0, dio_oe}, 128'd0);
        end
        ser_clk = 1'b0;
        wait_half();
        sel_n = 1'b1;
        wait_half();
        chk("R9", "cfg after abandoned instr", cfg_o, mreg);
        chk("R9", "enables idle", {126'd0, dio_oe, dout_oe}, 128'd0);
    endtask

    initial begin
        mreg = '0;
        repeat (3) @(negedge clk);
        chk("R1", "enables in reset", {126'd0, dio_oe, dout_oe}, 128'd0);
        rst_n = 1'b1;
        wait_half();
        chk("R1", "cfg after reset", cfg_o, 128'd0);
        chk("R1", "enables after reset", {126'd0, dio_oe, dout_oe}, 128'd0);

        // R2 R4: single write to register 3.
        txn(8'h03, 8, 8'hA5, 8'h00, 8'h00, 8'h00);
        // R4: four-byte write from 14 wrapping to 1, with a surplus byte ignored.
        txn(8'h6E, 40, 8'h11, 8'h22, 8'h34, 8'h46);
        // R6 R8: three-wire read of register 3 with tail bits.
        txn(8'h83, 11, 8'h00, 8'h00, 8'h00, 8'h00);
        // R6: four-byte read across the wrap.
        txn(8'hEE, 32, 8'h00, 8'h00, 8'h00, 8'h00);
        // R5: write to register 5 cut after five bits.
        txn(8'h05, 5, 8'hFF, 8'h00, 8'h00, 8'h00);
        txn(8'h85, 8, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R5", "reg5 untouched", {120'd0, cfg_o[5*8 +: 8]}, 128'h46 & 128'h0);
        // R9: abandoned instruction, then a normal read.
        abort_instr(8'h0F, 4);
        txn(8'h83, 8, 8'h00, 8'h00, 8'h00, 8'h00);
        // R7: switch to four-wire readback and read.
        txn(8'h00, 8, 8'h01, 8'h00, 8'h00, 8'h00);
        txn(8'h83, 10, 8'h00, 8'h00, 8'h00, 8'h00);
        txn(8'hAF, 17, 8'h00, 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule